// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Request Generator

This block turns the status flags of a FIFO-based serial port into interrupt requests. There are four sources: transmit FIFO empty, receive data (FIFO full or data ready), receive error, and break/overrun. Each source has its own registered request line. A three-bit code reports the most urgent pending request to the interrupt controller.

Enable gating differs between the sources. The transmit source has its own enable. The receive-data source has its own enable, and it counts the data-ready flag only when the port runs in asynchronous mode. The error and break sources are live when either the receive enable or the separate error enable is set, so errors can still be reported while receive-data requests are off. Each of the two data sources has a routing select that can move it from the CPU to a DMA engine. In that case the block emits a single-cycle DMA strobe in place of the CPU level.

Top module: `uart_irq_gen`

## Requirements
- R1: Every output is registered. It reflects the flags, enables and selects sampled at the previous rising clock edge.
- R2: `req_tx` is 1 when `en_tx` = 1, `flag_tx_empty` = 1 and `route_tx_dma` = 0.
- R3: `req_rx` is 1 when `en_rx` = 1, `route_rx_dma` = 0 and either `flag_rx_full` = 1 or (`flag_rx_ready` = 1 and `mode_async` = 1).
- R4: When `mode_async` = 0, `flag_rx_ready` has no effect on `req_rx` or `dma_rx`.
- R5: `req_err` is 1 when `flag_rx_err` = 1 and (`en_rx` = 1 or `en_err` = 1). With `en_rx` = 0 and `en_err` = 1, errors are requested while `req_rx` stays 0.
- R6: `req_brk` is 1 when (`flag_brk` = 1 or `flag_ovr` = 1) and (`en_rx` = 1 or `en_err` = 1). With both enables at 0, `req_err` and `req_brk` stay 0.
- R7: `top_src` encodes the highest-priority active CPU request line. The priority order is `req_brk` (4), then `req_err` (3), then `req_rx` (2), then `req_tx` (1). The value is 0 when no CPU request line is active.
- R8: When a data source's route select is 1, its CPU line is 0. Its DMA strobe (`dma_tx` / `dma_rx`) is 1 for exactly one cycle after a sampled edge where that source's gated condition (enable and flags, as in R2/R3 without the route term) rose from 0 to 1.
- R9: The route selects have no effect on `req_err` or `req_brk`.
- R10: A synchronous active-high `rst` clears every output to 0 and the stored gated conditions to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flag_tx_empty | input | 1 | Transmit FIFO data empty |
| flag_rx_full | input | 1 | Receive FIFO data full |
| flag_rx_ready | input | 1 | Receive data ready |
| flag_rx_err | input | 1 | Receive error |
| flag_brk | input | 1 | Break detected |
| flag_ovr | input | 1 | Overrun error |
| en_tx | input | 1 | Transmit interrupt enable |
| en_rx | input | 1 | Receive interrupt enable |
| en_err | input | 1 | Receive-error interrupt enable |
| mode_async | input | 1 | 1 = asynchronous mode |
| route_tx_dma | input | 1 | 1 = transmit source goes to DMA |
| route_rx_dma | input | 1 | 1 = receive source goes to DMA |
| req_brk | output | 1 | Break/overrun CPU request |
| req_err | output | 1 | Receive-error CPU request |
| req_rx | output | 1 | Receive-data CPU request |
| req_tx | output | 1 | Transmit CPU request |
| dma_rx | output | 1 | Receive DMA strobe |
| dma_tx | output | 1 | Transmit DMA strobe |
| top_src | output | 3 | Highest pending CPU source code |

## Verification
The only hidden state is the stored gated condition of each data source. If that state is wrong, it shows up one cycle after the condition rises: a DMA strobe goes missing, repeats, or comes back on a held condition. An error in any gating term shows up one cycle later on a single request line and on `top_src`. The bench therefore compares every output after every sampled edge, so each fault appears at its first occurrence.

// File: rtl/uart_irq_gen.sv
module uart_irq_gen (
  input  logic       clk,
  input  logic       rst,
  input  logic       flag_tx_empty,
  input  logic       flag_rx_full,
  input  logic       flag_rx_ready,
  input  logic       flag_rx_err,
  input  logic       flag_brk,
  input  logic       flag_ovr,
  input  logic       en_tx,
  input  logic       en_rx,
  input  logic       en_err,
  input  logic       mode_async,
  input  logic       route_tx_dma,
  input  logic       route_rx_dma,
  output logic       req_brk,
  output logic       req_err,
  output logic       req_rx,
  output logic       req_tx,
  output logic       dma_rx,
  output logic       dma_tx,
  output logic [2:0] top_src
);

  logic cond_tx, cond_rx, cond_err, cond_brk, err_on;
  logic cond_tx_q, cond_rx_q;
  logic nxt_tx, nxt_rx;
  logic [2:0] nxt_src;

  assign err_on   = en_rx | en_err;
  assign cond_tx  = en_tx & flag_tx_empty;
  assign cond_rx  = en_rx & (flag_rx_full | (mode_async & flag_rx_ready));
  assign cond_err = err_on & flag_rx_err;
  assign cond_brk = err_on & (flag_brk | flag_ovr);
  assign nxt_tx   = cond_tx & ~route_tx_dma;
  assign nxt_rx   = cond_rx & ~route_rx_dma;

  always_comb begin
    if (cond_brk)      nxt_src = 3'd4;
    else if (cond_err) nxt_src = 3'd3;
    else if (nxt_rx)   nxt_src = 3'd2;
    else if (nxt_tx)   nxt_src = 3'd1;
    else               nxt_src = 3'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_brk   <= 1'b0;
      req_err   <= 1'b0;
      req_rx    <= 1'b0;
      req_tx    <= 1'b0;
      dma_rx    <= 1'b0;
      dma_tx    <= 1'b0;
      top_src   <= 3'd0;
      cond_tx_q <= 1'b0;
      cond_rx_q <= 1'b0;
    end else begin
      req_brk   <= cond_brk;
      req_err   <= cond_err;
      req_rx    <= nxt_rx;
      req_tx    <= nxt_tx;
      dma_rx    <= route_rx_dma & cond_rx & ~cond_rx_q;
      dma_tx    <= route_tx_dma & cond_tx & ~cond_tx_q;
      top_src   <= nxt_src;
      cond_tx_q <= cond_tx;
      cond_rx_q <= cond_rx;
    end
  end

endmodule

module uart_irq_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       flag_tx_empty,
  input logic       flag_rx_full,
  input logic       flag_rx_ready,
  input logic       flag_rx_err,
  input logic       flag_brk,
  input logic       flag_ovr,
  input logic       en_tx,
  input logic       en_rx,
  input logic       en_err,
  input logic       mode_async,
  input logic       route_tx_dma,
  input logic       route_rx_dma,
  input logic       req_brk,
  input logic       req_err,
  input logic       req_rx,
  input logic       req_tx,
  input logic       dma_rx,
  input logic       dma_tx,
  input logic [2:0] top_src
);

  a_r2_tx_level: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (req_tx == $past(en_tx && flag_tx_empty && !route_tx_dma)));

  a_r4_sync_ready_ignored: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_async) && !$past(flag_rx_full)) |-> (!req_rx && !dma_rx));

  a_r5_err_without_rx: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_rx) && $past(en_err) && $past(flag_rx_err)) |-> (req_err && !req_rx));

  a_r6_masked: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en_rx) && !$past(en_err)) |-> (!req_err && !req_brk));

  a_r7_brk_top: assert property (@(posedge clk) disable iff (rst)
    req_brk |-> (top_src == 3'd4));

  a_r7_tx_lowest: assert property (@(posedge clk) disable iff (rst)
    (top_src == 3'd1) |-> (req_tx && !req_rx && !req_err && !req_brk));

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
    dma_tx |=> !dma_tx);

  a_r8_cpu_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(route_rx_dma)) |-> !req_rx);

  a_r10_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!req_brk && !req_err && !req_rx && !req_tx && !dma_rx && !dma_tx && top_src == 3'd0));

endmodule

bind uart_irq_gen uart_irq_gen_chk chk_i (.*);

// File: tb/uart_irq_gen_tb.sv
`timescale 1ns/1ps
module uart_irq_gen_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] v = '0;
  logic req_brk, req_err, req_rx, req_tx, dma_rx, dma_tx;
  logic [2:0] top_src;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  uart_irq_gen dut_i (
    .clk(clk), .rst(rst),
    .flag_tx_empty(v[0]), .flag_rx_full(v[1]), .flag_rx_ready(v[2]),
    .flag_rx_err(v[3]), .flag_brk(v[4]), .flag_ovr(v[5]),
    .en_tx(v[6]), .en_rx(v[7]), .en_err(v[8]), .mode_async(v[9]),
    .route_tx_dma(v[10]), .route_rx_dma(v[11]),
    .req_brk(req_brk), .req_err(req_err), .req_rx(req_rx), .req_tx(req_tx),
    .dma_rx(dma_rx), .dma_tx(dma_tx), .top_src(top_src)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_zero(input string tag);
    chk(tag, {req_brk, req_err, req_rx}, 3'd0);
    chk(tag, {req_tx, dma_rx, dma_tx}, 3'd0);
    chk(tag, top_src, 3'd0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ptx, prx;
    v = 12'hFFF;
    repeat (3) @(negedge clk);
    chk_zero("R10 reset");
    rst = 1'b0;
    ptx = 1'b0;
    prx = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 4096; i++) begin
        logic ctx, crx, on, etx, erx, eer, ebr;
        logic [2:0] es;
        v = 12'(pass == 0 ? i : 4095 - i);
        @(posedge clk);
        @(negedge clk);
        ctx = v[6] & v[0];
        crx = v[7] & (v[1] | (v[9] & v[2]));
        on  = v[7] | v[8];
        etx = ctx & ~v[10];
        erx = crx & ~v[11];
        eer = on & v[3];
        ebr = on & (v[4] | v[5]);
        es  = ebr ? 3'd4 : eer ? 3'd3 : erx ? 3'd2 : etx ? 3'd1 : 3'd0;
        chk("R1 R2 req_tx", {2'b0, req_tx}, {2'b0, etx});
        chk("R3 R4 req_rx", {2'b0, req_rx}, {2'b0, erx});
        chk("R5 R9 req_err", {2'b0, req_err}, {2'b0, eer});
        chk("R6 R9 req_brk", {2'b0, req_brk}, {2'b0, ebr});
        chk("R7 top_src", top_src, es);
        chk("R8 dma_tx", {2'b0, dma_tx}, {2'b0, v[10] & ctx & ~ptx});
        chk("R8 R4 dma_rx", {2'b0, dma_rx}, {2'b0, v[11] & crx & ~prx});
        ptx = ctx;
        prx = crx;
      end
    end
    v = 12'b1100_0100_0001;
    @(posedge clk); @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_zero("R10 reset mid-run");
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R10 R8 strobe after reset", {2'b0, dma_tx}, 3'd1);
    @(posedge clk); @(negedge clk);
    chk("R8 held condition", {2'b0, dma_tx}, 3'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule